// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block keeps the 13-bit program counter of a small processor core and decides, once per clock, which instruction address is fetched next. A decoder presents the class of the instruction now executing. The classes are sequential, jump, call, return and skip-taken. With the class come an 11-bit immediate target and the two page bits held in a separate latch register. The block drives the fetch address and a squash flag. The squash flag tells the execute stage that the instruction fetched in the current cycle must be discarded and run as a no-operation.

Jump and call targets are formed by placing the two page bits above the 11-bit immediate. A call saves the current fetch address on an eight-entry circular return stack. A return loads the whole 13-bit counter from that stack. Every jump, call, return and taken skip costs exactly one squashed slot. While a slot is squashed, the class presented for it is ignored.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, fetch_addr is 0x0000 and squash is 0. A squash that was pending when reset arrived is dropped, and the return stack is emptied.
- R2: With no squash pending, class code 0 (sequential) moves fetch_addr to fetch_addr+1, wrapping from 0x1FFF to 0x0000, and leaves squash at 0.
- R3: With no squash pending, class code 1 (jump) loads fetch_addr with {page_sel[1:0], imm_addr[10:0]} and raises squash for the following cycle.
- R4: With no squash pending, class code 2 (call) loads the same paged target as a jump and raises squash. It also pushes the fetch_addr value present in the call cycle onto the return stack.
- R5: With no squash pending, class code 3 (return) loads fetch_addr with the most recently pushed return address, removes that entry, and raises squash.
- R6: With no squash pending, class code 4 (skip taken) moves fetch_addr to fetch_addr+1 and raises squash for the following cycle.
- R7: In a cycle where squash is 1, ctl_class, imm_addr and page_sel have no effect. fetch_addr advances by one, squash returns to 0, and the return stack is not pushed or popped.
- R8: The return stack holds 8 entries and is circular. A ninth push without a pop overwrites the oldest entry, and no error is signalled. Pops return entries in last-in first-out order and continue to wrap around.
- R9: Class codes 5, 6 and 7 behave as sequential (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_class | input | 3 | Decoded class of the executing instruction (0 seq, 1 jump, 2 call, 3 return, 4 skip taken) |
| imm_addr | input | 11 | Immediate target for jump and call |
| page_sel | input | 2 | Page field of the page-latch register |
| fetch_addr | output | 13 | Address of the instruction fetched this cycle |
| squash | output | 1 | The instruction fetched this cycle is to be executed as a no-operation |

## Verification
Each effect of a class, whether the new fetch address, the squash flag or a stack push or pop, is registered on the rising edge that samples the class. Each effect is therefore due at the ports one edge later. A popped return address shows up only through the fetch address after a return edge. The bench changes inputs at the falling edge and compares outputs at the next falling edge, so every comparison sees exactly one rising edge of effect. Checks of the ignored squash slot compare the address that follows the slot, so a wrongly honoured jump or return inside the slot would show as a wrong address.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        CLS_SEQ  = 3'd0,
        CLS_JUMP = 3'd1,
        CLS_CALL = 3'd2,
        CLS_RET  = 3'd3,
        CLS_SKIP = 3'd4
    } ctl_cls_e;

    // Unused codes fall back to plain sequential flow.
    function automatic ctl_cls_e decode_cls(input logic [2:0] raw);
        case (raw)
            3'd1:    return CLS_JUMP;
            3'd2:    return CLS_CALL;
            3'd3:    return CLS_RET;
            3'd4:    return CLS_SKIP;
            default: return CLS_SEQ;
        endcase
    endfunction

endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top
);
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [SP_W-1:0]         sp;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [SP_W-1:0] sp_prev, sp_next;

    always_comb begin
        sp_prev = (stk_q.sp == '0)   ? LAST : stk_q.sp - 1'b1;
        sp_next = (stk_q.sp == LAST) ? '0   : stk_q.sp + 1'b1;
        top     = stk_q.mem[sp_prev];

        stk_d = stk_q;
        if (push) begin
            stk_d.mem[stk_q.sp] = push_val;
            stk_d.sp            = sp_next;
        end else if (pop) begin
            stk_d.sp            = sp_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));                                                // R7
    AST_PUSH_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> stk_q.mem[$past(stk_q.sp)] == $past(push_val));        // R4
    AST_PUSH_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && stk_q.sp == LAST) |=> stk_q.sp == '0);                 // R8
    AST_POP_BACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && stk_q.sp == '0) |=> stk_q.sp == LAST);                  // R8

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
    import pcs_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LIT_W = 11
) (
    input  logic [PC_W-1:0]       pc_q,
    input  logic                  squash_q,
    input  ctl_cls_e              cls,
    input  logic [LIT_W-1:0]      imm,
    input  logic [PC_W-LIT_W-1:0] page,
    input  logic [PC_W-1:0]       stk_top,
    output logic [PC_W-1:0]       pc_d,
    output logic                  squash_d,
    output logic                  push,
    output logic                  pop,
    output logic [PC_W-1:0]       push_val
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            squash;
        logic            push;
        logic            pop;
    } nxt_t;

    nxt_t            nxt;
    logic [PC_W-1:0] target;

    always_comb begin
        target     = {page, imm};
        nxt.pc     = pc_q + 1'b1;
        nxt.squash = 1'b0;
        nxt.push   = 1'b0;
        nxt.pop    = 1'b0;
        if (!squash_q) begin
            unique case (cls)
                CLS_JUMP: begin
                    nxt.pc     = target;
                    nxt.squash = 1'b1;
                end
                CLS_CALL: begin
                    nxt.pc     = target;
                    nxt.squash = 1'b1;
                    nxt.push   = 1'b1;
                end
                CLS_RET: begin
                    nxt.pc     = stk_top;
                    nxt.squash = 1'b1;
                    nxt.pop    = 1'b1;
                end
                CLS_SKIP: nxt.squash = 1'b1;
                default:  ;
            endcase
        end
        pc_d     = nxt.pc;
        squash_d = nxt.squash;
        push     = nxt.push;
        pop      = nxt.pop;
        push_val = pc_q;
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int LIT_W       = 11,
    parameter int STACK_DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            ctl_class,
    input  logic [LIT_W-1:0]      imm_addr,
    input  logic [PC_W-LIT_W-1:0] page_sel,
    output logic [PC_W-1:0]       fetch_addr,
    output logic                  squash
);
    localparam int HI_W = PC_W - LIT_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            squash;
    } seq_t;

    seq_t            seq_d, seq_q;
    ctl_cls_e        cls;
    logic [PC_W-1:0] pc_nx, stk_top, push_val;
    logic            sq_nx, push, pop;

    always_comb cls = decode_cls(ctl_class);

    pcs_next_pc #(.PC_W(PC_W), .LIT_W(LIT_W)) u_next (
        .pc_q     (seq_q.pc),
        .squash_q (seq_q.squash),
        .cls      (cls),
        .imm      (imm_addr),
        .page     (page_sel),
        .stk_top  (stk_top),
        .pc_d     (pc_nx),
        .squash_d (sq_nx),
        .push     (push),
        .pop      (pop),
        .push_val (push_val)
    );

    pcs_ret_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top      (stk_top)
    );

    always_comb begin
        seq_d.pc     = pc_nx;
        seq_d.squash = sq_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign fetch_addr = seq_q.pc;
    assign squash     = seq_q.squash;

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && cls == CLS_SEQ) |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1)) && !squash); // R2
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && cls == CLS_JUMP) |=> fetch_addr == {$past(page_sel), $past(imm_addr)});          // R3
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && cls == CLS_CALL) |=> fetch_addr == {$past(page_sel), $past(imm_addr)});          // R4
    AST_XFER_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && cls inside {CLS_JUMP, CLS_CALL, CLS_RET, CLS_SKIP}) |=> squash);                 // R6
    AST_SLOT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1)) && !squash);                      // R7
    AST_SLOT_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !push && !pop);                                                                   // R7

    initial assert (HI_W > 0);
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ctl = 3'd0;
    logic [10:0] imm = '0;
    logic [1:0]  pg = '0;
    logic [12:0] fetch_addr;
    logic        squash;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .ctl_class(ctl), .imm_addr(imm),
        .page_sel(pg), .fetch_addr(fetch_addr), .squash(squash)
    );

    // {class, imm, page, expected pc, expected squash}
    localparam int NV = 17;
    localparam logic [29:0] VEC [NV] = '{
        {3'd0, 11'h000, 2'd0, 13'h0001, 1'b0},
        {3'd0, 11'h000, 2'd0, 13'h0002, 1'b0},
        {3'd4, 11'h000, 2'd0, 13'h0003, 1'b1},
        {3'd1, 11'h555, 2'd2, 13'h0004, 1'b0},
        {3'd1, 11'h123, 2'd3, 13'h1923, 1'b1},
        {3'd0, 11'h000, 2'd0, 13'h1924, 1'b0},
        {3'd2, 11'h400, 2'd1, 13'h0C00, 1'b1},
        {3'd0, 11'h000, 2'd0, 13'h0C01, 1'b0},
        {3'd0, 11'h000, 2'd0, 13'h0C02, 1'b0},
        {3'd3, 11'h000, 2'd0, 13'h1924, 1'b1},
        {3'd0, 11'h000, 2'd0, 13'h1925, 1'b0},
        {3'd1, 11'h7FF, 2'd0, 13'h07FF, 1'b1},
        {3'd0, 11'h000, 2'd0, 13'h0800, 1'b0},
        {3'd7, 11'h3AA, 2'd3, 13'h0801, 1'b0},
        {3'd5, 11'h000, 2'd0, 13'h0802, 1'b0},
        {3'd4, 11'h000, 2'd0, 13'h0803, 1'b1},
        {3'd3, 11'h000, 2'd0, 13'h0804, 1'b0}
    };

    task automatic check(input string req, input logic [12:0] exp_pc, input logic exp_sq);
        checks++;
        if (fetch_addr !== exp_pc || squash !== exp_sq) begin
            errors++;
            $display("FAIL %s: pc %h sq %b, expected pc %h sq %b",
                     req, fetch_addr, squash, exp_pc, exp_sq);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [10:0] i, input logic [1:0] p);
        ctl = c; imm = i; pg = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string row_tag(input logic [2:0] c, input logic in_slot);
        if (in_slot) return "R7";
        case (c)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6";
            default: return "R9";
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] rec [1:9];
        logic        slot;
        repeat (3) @(negedge clk);
        check("R1 during reset", 13'h0000, 1'b0);
        rst_n = 1'b1;
        check("R1 after release", 13'h0000, 1'b0);

        slot = 1'b0;
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][29:27], VEC[k][26:16], VEC[k][15:14]);
            check(row_tag(VEC[k][29:27], slot), VEC[k][13:1], VEC[k][0]);
            slot = VEC[k][0];
        end

        // counter wrap at the top of the address space
        step(3'd1, 11'h7FF, 2'd3);
        check("R3 top page", 13'h1FFF, 1'b1);
        step(3'd0, 11'h000, 2'd0);
        check("R7 slot wraps", 13'h0000, 1'b0);
        step(3'd0, 11'h000, 2'd0);
        check("R2 after wrap", 13'h0001, 1'b0);

        // reset while a squash is pending
        step(3'd4, 11'h000, 2'd0);
        check("R6 skip", 13'h0002, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", 13'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 pending squash dropped", 13'h0000, 1'b0);

        // nine nested calls overflow the eight-entry stack
        for (int i = 1; i <= 9; i++) begin
            rec[i] = fetch_addr;
            step(3'd2, 11'(i * 64), 2'd0);
            check("R4 nested call", 13'(i * 64), 1'b1);
            step(3'd3, 11'h000, 2'd0);
            check("R7 slot after call", 13'(i * 64 + 1), 1'b0);
        end
        for (int j = 0; j < 9; j++) begin
            automatic logic [12:0] want = (j < 8) ? rec[9 - j] : rec[9];
            step(3'd3, 11'h000, 2'd0);
            check("R8 return order", want, 1'b1);
            step(3'd0, 11'h000, 2'd0);
            check("R5 after return", want + 13'd1, 1'b0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule